// File: doc/BRIEF.md
# Load Driver Protection Supervisor

This block is the digital supervisor for a bank of twelve power switches, arranged as six low-side/high-side pairs. It takes the control word already committed by the serial port, a one-cycle status-reset strobe, a hardware run pin, and the digital flags reported by the analog sensing. These flags are per-output over-current and open-load comparators, a temperature prewarning, a thermal shutdown and a supply undervoltage. From them it decides which switches may conduct and which open-load test currents are on, and it builds the status word that the serial port shifts out.

Time is counted in pulses of a `tick` enable. Each switch has its own short-circuit state machine: `SC_IDLE` moves to `SC_COUNT` on a sustained over-current and then to `SC_TRIP` when the selected delay runs out. It goes straight to `SC_TRIP` if the prewarning is active. It returns to `SC_IDLE` from `SC_COUNT` when the over-current or the drive goes away, and from `SC_TRIP` on a status reset. The supply supervisor moves from `UV_OK` to `UV_WAIT` on undervoltage and to `UV_FAIL` when its delay expires, and it returns to `UV_OK` once the supply is good. The thermal supervisor moves from `TH_RUN` to `TH_SHUT` on shutdown, to `TH_COOL` when the condition clears, and back to `TH_RUN` only on a status reset.

Control word layout (N = 12): bits [11:0] command outputs 0..11 (even index low-side, odd index high-side); bit 12 low enables open-load detection; bit 13 selects the long delays when high; bit 14 high requests normal operation. Status layout: bit 0 prewarning, bits [12:1] per-output state, bit 13 short-circuit, bit 14 standby, bit 15 supply fail.

Top module: `load_guard_top`

## Requirements
- R1: After reset no output has tripped, the supply-fail flag is clear and the thermal supervisor is in `TH_RUN`; with control word 0x7000 and all fault inputs low, `drv_en` is 0 and `status` is 0x0000.
- R2: `drv_en[i]` is high only when control bit i is high, output i has not tripped, standby is off, the supply supervisor is not in `UV_FAIL` and the thermal supervisor is in `TH_RUN`.
- R3: An over-current held on an enabled output for SC_LONG_TICKS ticks (control bit 13 high) or SC_SHORT_TICKS ticks (bit 13 low) disables that output in the cycle after the last tick and sets status bit 13. The count restarts whenever the over-current drops or the output is not driven.
- R4: An over-current on an enabled output while `temp_warn` is high disables that output and sets status bit 13 in the next cycle, with no tick needed.
- R5: A `srr_pulse` clears every short-circuit trip and status bit 13, which re-enables the outputs. A trip raised in the same cycle as the strobe still takes effect.
- R6: Undervoltage held for UV_LONG_TICKS ticks (bit 13 high) or UV_SHORT_TICKS ticks (bit 13 low) sets status bit 15 and disables all outputs. Outputs return in the cycle after `vs_low` falls. Bit 15 stays set until `srr_pulse`, and a strobe while the supply is still failing leaves it set.
- R7: `temp_shut` disables all outputs and forces `status` to 0xFFFF from the next cycle on. This holds until `temp_shut` has fallen and an `srr_pulse` has been given afterwards. A strobe while `temp_shut` is high has no effect.
- R8: `ol_src_en[i]` is high when control bit 12 is low and output i is not driven. `status[i+1]` then shows `ol_flag[i]`; otherwise it shows `drv_en[i]`.
- R9: Standby (`run_pin` low or control bit 14 low) turns all outputs off and reads as status bit 14 high.
- R10: Status bit 0 equals `temp_warn` in the same cycle whenever thermal shutdown is not forcing the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for all delay counters |
| ctrl_word | input | 15 | Committed control word |
| srr_pulse | input | 1 | One-cycle status-reset strobe |
| run_pin | input | 1 | Hardware run pin, low forces standby |
| oc_flag | input | 12 | Per-output over-current flags |
| ol_flag | input | 12 | Per-output open-load comparator results |
| temp_warn | input | 1 | Temperature prewarning |
| temp_shut | input | 1 | Thermal shutdown condition |
| vs_low | input | 1 | Supply undervoltage |
| drv_en | output | 12 | Switch enables |
| ol_src_en | output | 12 | Open-load test current enables |
| status | output | 16 | Status word for the serial port |

## Verification
The properties assume synchronous flag inputs that change only between clock edges. They also assume `srr_pulse` stands for a single committed write and is not a level. The reset-clearing property further assumes no `tick` and no prewarning in the strobe cycle. The stimulus drives every input just after the rising edge. It generates `tick` on a fixed one-in-three cadence, keeps `srr_pulse` to one cycle in the directed phase, and in the random phase holds supply and thermal faults for stretches so that the timers both expire and restart.

// File: rtl/lg_pkg.sv
package lg_pkg;
    typedef enum logic [1:0] {SC_IDLE, SC_COUNT, SC_TRIP} sc_state_t;
    typedef enum logic [1:0] {UV_OK, UV_WAIT, UV_FAIL} uv_state_t;
    typedef enum logic [1:0] {TH_RUN, TH_SHUT, TH_COOL} th_state_t;
endpackage

// File: rtl/lg_short_timer.sv
module lg_short_timer
    import lg_pkg::*;
#(
    parameter int LONG_TICKS  = 16,
    parameter int SHORT_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic oc,
    input  logic warn,
    input  logic long_sel,
    input  logic clr,
    output logic tripped
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    sc_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   limit_m1;
    logic            faulted;

    assign faulted  = armed && oc;
    assign limit_m1 = long_sel ? CW'(LONG_TICKS - 1) : CW'(SHORT_TICKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SC_IDLE, SC_COUNT: begin
                if (!faulted) begin
                    state_d = SC_IDLE;
                    cnt_d   = '0;
                end else if (warn) begin
                    state_d = SC_TRIP;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= limit_m1) begin
                        state_d = SC_TRIP;
                        cnt_d   = '0;
                    end else begin
                        state_d = SC_COUNT;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end else begin
                    state_d = SC_COUNT;
                end
            end
            SC_TRIP: begin
                if (clr) state_d = SC_IDLE;
            end
            default: begin
                state_d = SC_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        tripped = (state_q == SC_TRIP);
    end
endmodule

// File: rtl/lg_uv_supervisor.sv
module lg_uv_supervisor
    import lg_pkg::*;
#(
    parameter int LONG_TICKS  = 12,
    parameter int SHORT_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vs_low,
    input  logic long_sel,
    input  logic clr,
    output logic uv_block,
    output logic psf
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    uv_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] limit_m1;
    logic          psf_q;

    assign limit_m1 = long_sel ? CW'(LONG_TICKS - 1) : CW'(SHORT_TICKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UV_OK;
            cnt_q   <= '0;
            psf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            psf_q   <= (state_d == UV_FAIL) || (psf_q && !clr);
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            UV_OK: begin
                cnt_d = '0;
                if (vs_low) state_d = UV_WAIT;
            end
            UV_WAIT: begin
                if (!vs_low) begin
                    state_d = UV_OK;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= limit_m1) begin
                        state_d = UV_FAIL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            UV_FAIL: begin
                if (!vs_low) state_d = UV_OK;
            end
            default: begin
                state_d = UV_OK;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        uv_block = (state_q == UV_FAIL);
        psf      = psf_q;
    end
endmodule

// File: rtl/lg_thermal_supervisor.sv
module lg_thermal_supervisor
    import lg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic temp_shut,
    input  logic clr,
    output logic th_block
);
    th_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_RUN:  if (temp_shut) state_d = TH_SHUT;
            TH_SHUT: if (!temp_shut) state_d = TH_COOL;
            TH_COOL: begin
                if (temp_shut)  state_d = TH_SHUT;
                else if (clr)   state_d = TH_RUN;
            end
            default: state_d = TH_RUN;
        endcase
    end

    always_comb begin
        th_block = (state_q != TH_RUN);
    end
endmodule

// File: rtl/load_guard_top.sv
module load_guard_top #(
    parameter int N_PAIRS        = 6,
    parameter int SC_LONG_TICKS  = 16,
    parameter int SC_SHORT_TICKS = 2,
    parameter int UV_LONG_TICKS  = 12,
    parameter int UV_SHORT_TICKS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [2*N_PAIRS+2:0]   ctrl_word,
    input  logic                   srr_pulse,
    input  logic                   run_pin,
    input  logic [2*N_PAIRS-1:0]   oc_flag,
    input  logic [2*N_PAIRS-1:0]   ol_flag,
    input  logic                   temp_warn,
    input  logic                   temp_shut,
    input  logic                   vs_low,
    output logic [2*N_PAIRS-1:0]   drv_en,
    output logic [2*N_PAIRS-1:0]   ol_src_en,
    output logic [2*N_PAIRS+3:0]   status
);
    localparam int N_OUT    = 2 * N_PAIRS;
    localparam int ST_W     = N_OUT + 4;
    localparam int CB_OLOFF = N_OUT;
    localparam int CB_LONG  = N_OUT + 1;
    localparam int CB_RUN   = N_OUT + 2;
    localparam int SB_SHORT = N_OUT + 1;
    localparam int SB_STBY  = N_OUT + 2;
    localparam int SB_PSF   = N_OUT + 3;

    logic [N_OUT-1:0] sc_trip;
    logic             uv_block;
    logic             psf_q;
    logic             th_block;
    logic             standby;
    logic             global_off;

    assign standby    = !ctrl_word[CB_RUN] || !run_pin;
    assign global_off = standby || uv_block || th_block;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        lg_short_timer #(
            .LONG_TICKS (SC_LONG_TICKS),
            .SHORT_TICKS(SC_SHORT_TICKS)
        ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .armed   (drv_en[i]),
            .oc      (oc_flag[i]),
            .warn    (temp_warn),
            .long_sel(ctrl_word[CB_LONG]),
            .clr     (srr_pulse),
            .tripped (sc_trip[i])
        );

        assign drv_en[i]    = ctrl_word[i] && !sc_trip[i] && !global_off;
        assign ol_src_en[i] = !ctrl_word[CB_OLOFF] && !drv_en[i];
    end

    lg_uv_supervisor #(
        .LONG_TICKS (UV_LONG_TICKS),
        .SHORT_TICKS(UV_SHORT_TICKS)
    ) u_uv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .vs_low  (vs_low),
        .long_sel(ctrl_word[CB_LONG]),
        .clr     (srr_pulse),
        .uv_block(uv_block),
        .psf     (psf_q)
    );

    lg_thermal_supervisor u_th (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_shut(temp_shut),
        .clr      (srr_pulse),
        .th_block (th_block)
    );

    always_comb begin
        if (th_block) begin
            status = {ST_W{1'b1}};
        end else begin
            status[0] = temp_warn;
            for (int k = 0; k < N_OUT; k++) begin
                status[k+1] = ol_src_en[k] ? ol_flag[k] : drv_en[k];
            end
            status[SB_SHORT] = |sc_trip;
            status[SB_STBY]  = standby;
            status[SB_PSF]   = psf_q;
        end
    end
endmodule

// File: rtl/lg_checker.sv
module lg_checker #(
    parameter int N_OUT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [N_OUT+2:0] ctrl_word,
    input logic             srr_pulse,
    input logic             run_pin,
    input logic [N_OUT-1:0] oc_flag,
    input logic             temp_warn,
    input logic             temp_shut,
    input logic [N_OUT-1:0] drv_en,
    input logic [N_OUT-1:0] ol_src_en,
    input logic [N_OUT+3:0] status,
    input logic [N_OUT-1:0] sc_trip,
    input logic             psf_q
);
    p_drv_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en & ~ctrl_word[N_OUT-1:0]) == '0);

    p_warn_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_warn && ((drv_en & oc_flag) != '0)) |=>
        ((sc_trip & $past(drv_en & oc_flag)) == $past(drv_en & oc_flag)));

    p_srr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (srr_pulse && !tick && !temp_warn) |=> (sc_trip == '0));

    p_psf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psf_q && !srr_pulse) |=> psf_q);

    p_shut_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_shut |=> (status == '1 && drv_en == '0));

    p_ol_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_src_en & drv_en) == '0);

    p_standby_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_pin || !ctrl_word[N_OUT+2]) |-> (drv_en == '0));

    p_warn_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '1) |-> (status[0] == temp_warn));
endmodule

bind load_guard_top lg_checker #(.N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ctrl_word(ctrl_word),
    .srr_pulse(srr_pulse),
    .run_pin  (run_pin),
    .oc_flag  (oc_flag),
    .temp_warn(temp_warn),
    .temp_shut(temp_shut),
    .drv_en   (drv_en),
    .ol_src_en(ol_src_en),
    .status   (status),
    .sc_trip  (sc_trip),
    .psf_q    (psf_q)
);

// File: tb/tb_load_guard_top.sv
module tb_load_guard_top;
    localparam int N   = 12;
    localparam int SCL = 16;
    localparam int SCS = 2;
    localparam int UVL = 12;
    localparam int UVS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [N+2:0]  ctrl_word = 15'h7000;
    logic          srr_pulse = 1'b0;
    logic          run_pin = 1'b1;
    logic [N-1:0]  oc_flag = '0;
    logic [N-1:0]  ol_flag = '0;
    logic          temp_warn = 1'b0;
    logic          temp_shut = 1'b0;
    logic          vs_low = 1'b0;
    logic [N-1:0]  drv_en;
    logic [N-1:0]  ol_src_en;
    logic [N+3:0]  status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    load_guard_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl_word),
        .srr_pulse(srr_pulse), .run_pin(run_pin), .oc_flag(oc_flag),
        .ol_flag(ol_flag), .temp_warn(temp_warn), .temp_shut(temp_shut),
        .vs_low(vs_low), .drv_en(drv_en), .ol_src_en(ol_src_en), .status(status)
    );

    // Reference model state
    int m_cnt [N];
    bit m_trip [N];
    int m_uv_st, m_uv_cnt, m_th;
    bit m_psf;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Tick on a one-in-three cadence
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph = (ph == 2) ? 0 : ph + 1;
            tick = (ph == 0);
        end
    end

    // Per-cycle reference comparison and model update
    always @(negedge clk) begin
        bit stby, blk, anytrip, lng;
        logic [N-1:0] e_en, e_ol;
        logic [N+3:0] e_st;
        int lim, ulim, nst;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_trip[i] = 0; end
            m_uv_st = 0; m_uv_cnt = 0; m_th = 0; m_psf = 0;
        end else begin
            stby = !ctrl_word[N+2] || !run_pin;
            blk  = stby || (m_uv_st == 2) || (m_th != 0);
            anytrip = 0;
            for (int i = 0; i < N; i++) begin
                e_en[i] = ctrl_word[i] && !m_trip[i] && !blk;
                e_ol[i] = !ctrl_word[N] && !e_en[i];
                anytrip |= m_trip[i];
            end
            if (m_th != 0) e_st = '1;
            else begin
                e_st[0] = temp_warn;
                for (int i = 0; i < N; i++) e_st[i+1] = e_ol[i] ? ol_flag[i] : e_en[i];
                e_st[N+1] = anytrip; e_st[N+2] = stby; e_st[N+3] = m_psf;
            end
            check(32'(drv_en), 32'(e_en), "R2 R3 R4 R5 R6 R7 R9 model drv_en");
            check(32'(ol_src_en), 32'(e_ol), "R8 model ol_src_en");
            check(32'(status), 32'(e_st), "R6 R7 R8 R9 R10 model status");
            // next state
            lng  = ctrl_word[N+1];
            lim  = lng ? SCL : SCS;
            ulim = lng ? UVL : UVS;
            for (int i = 0; i < N; i++) begin
                if (m_trip[i]) begin
                    if (srr_pulse) m_trip[i] = 0;
                end else if (e_en[i] && oc_flag[i]) begin
                    if (temp_warn) begin m_trip[i] = 1; m_cnt[i] = 0; end
                    else if (tick) begin
                        if (m_cnt[i] + 1 >= lim) begin m_trip[i] = 1; m_cnt[i] = 0; end
                        else m_cnt[i]++;
                    end
                end else m_cnt[i] = 0;
            end
            nst = m_uv_st;
            if (m_uv_st == 0) begin m_uv_cnt = 0; if (vs_low) nst = 1; end
            else if (m_uv_st == 1) begin
                if (!vs_low) begin nst = 0; m_uv_cnt = 0; end
                else if (tick) begin
                    if (m_uv_cnt + 1 >= ulim) begin nst = 2; m_uv_cnt = 0; end
                    else m_uv_cnt++;
                end
            end else if (!vs_low) nst = 0;
            m_psf = (nst == 2) || (m_psf && !srr_pulse);
            m_uv_st = nst;
            if (m_th == 0) begin if (temp_shut) m_th = 1; end
            else if (m_th == 1) begin if (!temp_shut) m_th = 2; end
            else begin if (temp_shut) m_th = 1; else if (srr_pulse) m_th = 0; end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look;
        @(negedge clk); #1;
    endtask

    task automatic strobe;
        srr_pulse = 1'b1; cyc(1); srr_pulse = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state
        look; check(32'(drv_en), 0, "R1 drv_en"); check(32'(status), 32'h0000, "R1 status");
        check(32'(ol_src_en), 0, "R1 ol_src_en");
        // R2 command mapping
        cyc(1); ctrl_word = 15'h7000 | 15'h0A5A; cyc(3);
        look; check(32'(drv_en), 32'hA5A, "R2 drv_en"); check(32'(status), 32'h14B4, "R2 status");
        // R9 standby by pin and by software bit
        cyc(1); run_pin = 1'b0; cyc(2);
        look; check(32'(drv_en), 0, "R9 pin"); check(32'(status), 32'h4000, "R9 status");
        cyc(1); run_pin = 1'b1; ctrl_word = 15'h3000 | 15'h0A5A; cyc(2);
        look; check(32'(drv_en), 0, "R9 soft bit"); check(32'(status[14]), 1, "R9 bit14");
        cyc(1); ctrl_word = 15'h7000; cyc(2);
        // R10 prewarning follows input
        temp_warn = 1'b1; look; check(32'(status[0]), 1, "R10 warn high");
        cyc(1); temp_warn = 1'b0; look; check(32'(status[0]), 0, "R10 warn low");
        // R8 open-load reporting
        cyc(1); ctrl_word = 15'h6000 | 15'h000F; ol_flag = 12'h0F3; cyc(2);
        look; check(32'(ol_src_en), 32'hFF0, "R8 src"); check(32'(status), 32'h01FE, "R8 status");
        cyc(1); ol_flag = '0; ctrl_word = 15'h7001; cyc(2);
        // R3 long delay with restart
        oc_flag = 12'h001; cyc(30); oc_flag = '0; cyc(2); oc_flag = 12'h001; cyc(30);
        look; check(32'(drv_en[0]), 1, "R3 restart keeps output on");
        cyc(40);
        look; check(32'(drv_en[0]), 0, "R3 long trip"); check(32'(status[13]), 1, "R3 short flag");
        // R5 reset of trip
        cyc(1); oc_flag = '0; strobe; cyc(1);
        look; check(32'(drv_en[0]), 1, "R5 re-enabled"); check(32'(status[13]), 0, "R5 flag cleared");
        // R3 short delay
        cyc(1); ctrl_word = 15'h5003; oc_flag = 12'h001; cyc(15);
        look; check(32'(drv_en[0]), 0, "R3 short trip");
        // R5 new fault wins over same-cycle strobe (output 1 via prewarning)
        cyc(1); temp_warn = 1'b1; oc_flag = 12'h003; strobe; temp_warn = 1'b0; oc_flag = 12'h000; cyc(1);
        look; check(32'(drv_en[1:0]), 32'h1, "R5 new fault wins"); check(32'(status[13]), 1, "R5 flag kept");
        cyc(1); strobe; cyc(1);
        // R4 prewarning trip on output 2, long delay selected
        ctrl_word = 15'h7004; cyc(1); temp_warn = 1'b1; oc_flag = 12'h004; cyc(2);
        look; check(32'(drv_en[2]), 0, "R4 immediate trip");
        cyc(1); temp_warn = 1'b0; oc_flag = '0; strobe; cyc(1);
        // R6 undervoltage
        ctrl_word = 15'h70FF; cyc(1); vs_low = 1'b1; cyc(10);
        look; check(32'(drv_en), 32'h0FF, "R6 before expiry");
        cyc(50);
        look; check(32'(drv_en), 0, "R6 all off"); check(32'(status[15]), 1, "R6 flag set");
        cyc(1); strobe; cyc(1);
        look; check(32'(status[15]), 1, "R6 strobe while failing");
        cyc(1); vs_low = 1'b0; cyc(1);
        look; check(32'(drv_en), 32'h0FF, "R6 recovered"); check(32'(status[15]), 1, "R6 flag held");
        cyc(1); strobe; cyc(1);
        look; check(32'(status[15]), 0, "R6 flag cleared");
        // R7 thermal shutdown
        cyc(1); temp_shut = 1'b1; cyc(2);
        look; check(32'(status), 32'hFFFF, "R7 all ones"); check(32'(drv_en), 0, "R7 outputs off");
        cyc(1); strobe; temp_shut = 1'b0; cyc(2);
        look; check(32'(status), 32'hFFFF, "R7 strobe during shutdown ignored");
        cyc(1); strobe; cyc(1);
        look; check(32'(drv_en), 32'h0FF, "R7 restored"); check(32'(status[15:13]), 0, "R7 status normal");
        // Random phase against the reference model
        for (int c = 0; c < 4000; c++) begin
            cyc(1);
            if ($urandom % 24 == 0) ctrl_word = 15'($urandom) | 15'h4000;
            if ($urandom % 64 == 0) run_pin = ~run_pin;
            oc_flag   = 12'($urandom & $urandom & $urandom);
            ol_flag   = 12'($urandom);
            srr_pulse = ($urandom % 20 == 0);
            if ($urandom % 40 == 0) temp_warn = ~temp_warn;
            if ($urandom % 150 == 0) temp_shut = ~temp_shut;
            if ($urandom % 60 == 0) vs_low = ~vs_low;
        end
        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule